// File: doc/BRIEF.md
# Pulsed Radar Timing Controller

This block produces the timing waveforms for one repetition period of a monostatic pulsed radar. It drives the transmit/receive switch gate, the transmit pulse, a one-phase beam-orientation enable, and the receive window that lets the ADC sample. Each period begins with a short arming phase. The transmit pulse follows, and its width is chosen from four fixed values by a 2-bit code. A guard phase keeps the switch in its transmit position until a fixed 150 µs after the end of arming. A wait phase follows, then the receive window, then a dead phase that fills out the rest of the pulse repetition time (PRT).

All durations count whole microseconds. A prescaler makes the microsecond tick from the system clock, and its divisor is a parameter. The PRT, pulse-width code, window start and window length are plain inputs. The block latches them at the start of every period, so software may change them at any time. When run-enable is first seen high in idle, one initialization cycle loads the settings, and the first period starts on the next clock. If run-enable is low when a period ends, the block returns to idle.

Top module: `radar_pulse_timer`

## Requirements
- R1: After reset, and for as long as `run_en` stays low in idle, all four outputs are low and no period starts.
- R2: When `run_en` is seen high in idle, one initialization cycle with all outputs low follows, and then a period starts. For the first ARM_US µs of every period, `beam_en` and `tr_gate` are high and `tx_pulse` is low.
- R3: `tx_pulse` rises ARM_US µs into the period and stays high for the width set by `cfg_pw_code`: 2'b00 gives 20 µs, 2'b01 gives 60 µs, 2'b10 gives 80 µs and 2'b11 gives 100 µs.
- R4: `tr_gate` stays high until ARM_US+150 µs into the period, which is (150 − width) µs after `tx_pulse` falls, and is low for the rest of the period.
- R5: `rx_window` is high from µs max(`cfg_win_start_us`, ARM_US+150) of the period for `cfg_win_len_us` µs. The window is cut short so that it closes at least 1 µs before the period ends. A zero length gives no window.
- R6: A period lasts max(`cfg_prt_us`, ARM_US+151) µs, and one µs is TICK_DIV clock cycles. The next period starts on the clock right after the last one, with no gap between them.
- R7: All settings are sampled on the clock that starts a period. A change made during a period has no effect until the next period.
- R8: If `run_en` is low on the clock where a period ends, the period still runs to its end, after which the block stays idle with all outputs low. A rise of `tr_gate` is always preceded by a set `run_en` or by the initialization cycle.
- R9: `tx_pulse` is never high while `tr_gate` is low, `rx_window` is never high while `tr_gate` is high, and at most one of `tx_pulse`, `beam_en` and `rx_window` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Allows periods to start; checked in idle and at each period end |
| cfg_prt_us | input | TW | Pulse repetition time in µs |
| cfg_pw_code | input | 2 | Transmit pulse width select |
| cfg_win_start_us | input | TW | Receive window start, in µs from period start |
| cfg_win_len_us | input | TW | Receive window length in µs |
| tr_gate | output | 1 | Transmit/receive switch gate, high = transmit side |
| tx_pulse | output | 1 | Transmit pulse |
| beam_en | output | 1 | Beam-orientation enable during arming |
| rx_window | output | 1 | Receive window / ADC enable |

## Verification
On every cycle, the assertions check the ordering rules between the outputs: transmit only inside the gate, the window only outside it, arming with the gate high and no transmit, and the switch still high when the pulse falls. They also check that the gate rises only with run permission, and that no period starts straight out of an open window. Only the bench's scenarios can show the exact edge positions. These are the per-code pulse widths, the 150 µs gate span, and the clamped window and period lengths. The bench also shows that settings changed mid-period are ignored, and that a period is completed after run-enable drops.

// File: rtl/rpt_pkg.sv
// Shared types for the pulsed radar timing controller.
// Assumes: phase encoding is internal and only decoded inside the top module.
package rpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_ARM   = 3'd2,
        ST_TX    = 3'd3,
        ST_GUARD = 3'd4,
        ST_WAIT  = 3'd5,
        ST_WIN   = 3'd6,
        ST_DONE  = 3'd7
    } rpt_state_e;

endpackage

// File: rtl/rpt_tick_div.sv
// Microsecond tick prescaler: pulses `tick` for one clock every DIV clocks.
// Assumes: `clr` holds the count at zero, so the first tick after clr drops
// comes exactly DIV clocks later.
module rpt_tick_div #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_passthru
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick = ~clr;
        end else begin : g_count
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;

            // Free count of clocks within one microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == LAST) && !clr;
        end
    endgenerate

endmodule

// File: rtl/rpt_cfg_latch.sv
// Setting sampler: on `load` it turns the raw settings into absolute phase
// boundaries (µs from period start) and holds them for the whole period.
// Assumes: TR_SPAN_US is larger than every pulse width value.
module rpt_cfg_latch #(
    parameter int TW         = 16,
    parameter int ARM_US     = 1,
    parameter int TR_SPAN_US = 150,
    parameter int PW0_US     = 20,
    parameter int PW1_US     = 60,
    parameter int PW2_US     = 80,
    parameter int PW3_US     = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] prt_us,
    input  logic [1:0]    pw_code,
    input  logic [TW-1:0] win_start_us,
    input  logic [TW-1:0] win_len_us,
    output logic [TW:0]   tx_end,
    output logic [TW:0]   win_beg,
    output logic [TW:0]   win_end,
    output logic [TW:0]   prt_end
);

    localparam int CW      = TW + 1;
    localparam int TR_END  = ARM_US + TR_SPAN_US;
    localparam logic [CW-1:0] TR_END_C  = CW'(TR_END);
    localparam logic [CW-1:0] PRT_MIN_C = CW'(TR_END + 1);

    logic [CW-1:0] pw_sel;
    logic [CW-1:0] prt_eff;
    logic [CW-1:0] ws_eff;
    logic [CW-1:0] wend_raw;
    logic [CW-1:0] wend_cap;
    logic [CW-1:0] wend_eff;

    // Width lookup for the 2-bit pulse width code.
    always_comb begin
        case (pw_code)
            2'b00:   pw_sel = CW'(PW0_US);
            2'b01:   pw_sel = CW'(PW1_US);
            2'b10:   pw_sel = CW'(PW2_US);
            default: pw_sel = CW'(PW3_US);
        endcase
    end

    // Clamp period and window into the legal frame.
    always_comb begin
        prt_eff  = ({1'b0, prt_us} < PRT_MIN_C) ? PRT_MIN_C : {1'b0, prt_us};
        ws_eff   = ({1'b0, win_start_us} < TR_END_C) ? TR_END_C : {1'b0, win_start_us};
        wend_raw = ws_eff + {1'b0, win_len_us};
        wend_cap = prt_eff - 1'b1;
        wend_eff = (wend_raw > wend_cap) ? wend_cap : wend_raw;
    end

    // Hold the boundaries for the period that starts with this load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_end  <= '0;
            win_beg <= '0;
            win_end <= '0;
            prt_end <= '0;
        end else if (load) begin
            tx_end  <= CW'(ARM_US) + pw_sel;
            win_beg <= ws_eff;
            win_end <= wend_eff;
            prt_end <= prt_eff;
        end
    end

endmodule

// File: rtl/rpt_phase_fsm.sv
// Period sequencer: counts elapsed microseconds and steps through arm,
// transmit, guard, wait, window and dead phases; restarts or idles at PRT end.
// Assumes: boundaries ordered ARM_US < tx_end < TR_END <= win_beg, and
// win_end < prt_end, as produced by rpt_cfg_latch.
module rpt_phase_fsm
    import rpt_pkg::*;
#(
    parameter int TW         = 16,
    parameter int ARM_US     = 1,
    parameter int TR_SPAN_US = 150
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          tick,
    input  logic [TW:0]   tx_end,
    input  logic [TW:0]   win_beg,
    input  logic [TW:0]   win_end,
    input  logic [TW:0]   prt_end,
    output rpt_state_e    state_q,
    output logic          cfg_load,
    output logic          tick_clr
);

    localparam int CW = TW + 1;
    localparam logic [CW-1:0] ARM_C    = CW'(ARM_US);
    localparam logic [CW-1:0] TR_END_C = CW'(ARM_US + TR_SPAN_US);

    rpt_state_e    state_d;
    rpt_state_e    phase_at_next;
    logic [CW-1:0] us_q;
    logic [CW-1:0] us_next;
    logic [CW-1:0] us_d;
    logic          running;
    logic          wrap;

    assign running  = (state_q != ST_IDLE) && (state_q != ST_LOAD);
    assign us_next  = us_q + 1'b1;
    assign wrap     = running && tick && (us_next >= prt_end);
    assign cfg_load = (state_q == ST_LOAD) || (wrap && run_en);
    assign tick_clr = !running;

    // Phase that owns the microsecond about to begin.
    always_comb begin
        if (us_next >= win_end) begin
            phase_at_next = ST_DONE;
        end else if (us_next >= win_beg) begin
            phase_at_next = ST_WIN;
        end else if (us_next >= TR_END_C) begin
            phase_at_next = ST_WAIT;
        end else if (us_next >= tx_end) begin
            phase_at_next = ST_GUARD;
        end else if (us_next >= ARM_C) begin
            phase_at_next = ST_TX;
        end else begin
            phase_at_next = ST_ARM;
        end
    end

    // Next phase and elapsed-time selection.
    always_comb begin
        state_d = state_q;
        us_d    = us_q;
        case (state_q)
            ST_IDLE: begin
                us_d = '0;
                if (run_en) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                us_d    = '0;
                state_d = ST_ARM;
            end
            default: begin
                if (wrap) begin
                    us_d    = '0;
                    state_d = run_en ? ST_ARM : ST_IDLE;
                end else if (tick) begin
                    us_d    = us_next;
                    state_d = phase_at_next;
                end
            end
        endcase
    end

    // Phase and elapsed-time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            us_q    <= '0;
        end else begin
            state_q <= state_d;
            us_q    <= us_d;
        end
    end

endmodule

// File: rtl/radar_pulse_timer.sv
// Pulsed radar timing controller top: prescaler, per-period setting latch and
// phase sequencer; outputs are decoded from the registered phase.
// Assumes: synchronous active-low reset; settings may change at any time.
module radar_pulse_timer
    import rpt_pkg::*;
#(
    parameter int TICK_DIV   = 125,
    parameter int TW         = 16,
    parameter int ARM_US     = 1,
    parameter int TR_SPAN_US = 150,
    parameter int PW0_US     = 20,
    parameter int PW1_US     = 60,
    parameter int PW2_US     = 80,
    parameter int PW3_US     = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [TW-1:0] cfg_prt_us,
    input  logic [1:0]    cfg_pw_code,
    input  logic [TW-1:0] cfg_win_start_us,
    input  logic [TW-1:0] cfg_win_len_us,
    output logic          tr_gate,
    output logic          tx_pulse,
    output logic          beam_en,
    output logic          rx_window
);

    rpt_state_e  state_q;
    logic        tick;
    logic        tick_clr;
    logic        cfg_load;
    logic [TW:0] tx_end;
    logic [TW:0] win_beg;
    logic [TW:0] win_end;
    logic [TW:0] prt_end;

    rpt_tick_div #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    rpt_cfg_latch #(
        .TW(TW), .ARM_US(ARM_US), .TR_SPAN_US(TR_SPAN_US),
        .PW0_US(PW0_US), .PW1_US(PW1_US), .PW2_US(PW2_US), .PW3_US(PW3_US)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (cfg_load),
        .prt_us       (cfg_prt_us),
        .pw_code      (cfg_pw_code),
        .win_start_us (cfg_win_start_us),
        .win_len_us   (cfg_win_len_us),
        .tx_end       (tx_end),
        .win_beg      (win_beg),
        .win_end      (win_end),
        .prt_end      (prt_end)
    );

    rpt_phase_fsm #(.TW(TW), .ARM_US(ARM_US), .TR_SPAN_US(TR_SPAN_US)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick     (tick),
        .tx_end   (tx_end),
        .win_beg  (win_beg),
        .win_end  (win_end),
        .prt_end  (prt_end),
        .state_q  (state_q),
        .cfg_load (cfg_load),
        .tick_clr (tick_clr)
    );

    // Output decode from the registered phase.
    always_comb begin
        tr_gate   = (state_q == ST_ARM) || (state_q == ST_TX) || (state_q == ST_GUARD);
        tx_pulse  = (state_q == ST_TX);
        beam_en   = (state_q == ST_ARM);
        rx_window = (state_q == ST_WIN);
    end

endmodule

// File: rtl/rpt_checker.sv
// Property checker for radar_pulse_timer, attached by bind below.
// Assumes: reset is held for at least one clock at start.
module rpt_checker
    import rpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input rpt_state_e st,
    input logic       tr_gate,
    input logic       tx_pulse,
    input logic       beam_en,
    input logic       rx_window
);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !run_en) |=> (st == ST_IDLE)); // R1

    AST_INIT_THEN_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> beam_en); // R2

    AST_ARM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        beam_en |-> (tr_gate && !tx_pulse)); // R2

    AST_TX_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_pulse) |-> tr_gate); // R4

    AST_WIN_NOT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_window |=> !beam_en); // R5

    AST_GATE_RISE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_gate) |-> ($past(run_en) || $past(st) == ST_LOAD)); // R8

    AST_TX_INSIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pulse |-> tr_gate); // R9

    AST_WIN_OUTSIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_window |-> !tr_gate); // R9

    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_pulse, beam_en, rx_window})); // R9

endmodule

bind radar_pulse_timer rpt_checker u_rpt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .st        (state_q),
    .tr_gate   (tr_gate),
    .tx_pulse  (tx_pulse),
    .beam_en   (beam_en),
    .rx_window (rx_window)
);

// File: tb/radar_pulse_timer_bench.sv
module radar_pulse_timer_bench;

    localparam int DIV  = 2;
    localparam int TW   = 16;
    localparam int ARM  = 1;
    localparam int SPAN = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [TW-1:0] cfg_prt_us = '0;
    logic [1:0]    cfg_pw_code = '0;
    logic [TW-1:0] cfg_win_start_us = '0;
    logic [TW-1:0] cfg_win_len_us = '0;
    logic          tr_gate, tx_pulse, beam_en, rx_window;

    int n_vec = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    radar_pulse_timer #(
        .TICK_DIV(DIV), .TW(TW), .ARM_US(ARM), .TR_SPAN_US(SPAN),
        .PW0_US(20), .PW1_US(60), .PW2_US(80), .PW3_US(100)
    ) u_radar_pulse_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cfg_prt_us(cfg_prt_us), .cfg_pw_code(cfg_pw_code),
        .cfg_win_start_us(cfg_win_start_us), .cfg_win_len_us(cfg_win_len_us),
        .tr_gate(tr_gate), .tx_pulse(tx_pulse), .beam_en(beam_en), .rx_window(rx_window)
    );

    // Width in µs for each code, per R3.
    function automatic int width_of(int code);
        case (code)
            0: return 20;
            1: return 60;
            2: return 80;
            default: return 100;
        endcase
    endfunction

    // Period length in µs after the minimum clamp (R6).
    function automatic int period_of(int prt);
        return (prt < ARM + SPAN + 1) ? ARM + SPAN + 1 : prt;
    endfunction

    // Expected {tr, tx, beam, win} at microsecond t of a period.
    function automatic logic [3:0] expect_at(int t, int prt, int code, int ws, int wl);
        int gate_end, w0, w1, p;
        logic tr, tx, bm, wn;
        gate_end = ARM + SPAN;
        p  = period_of(prt);
        w0 = (ws < gate_end) ? gate_end : ws;
        w1 = (w0 + wl > p - 1) ? p - 1 : w0 + wl;
        bm = (t < ARM);
        tx = (t >= ARM) && (t < ARM + width_of(code));
        tr = (t < gate_end);
        wn = (t >= w0) && (t < w1);
        return {tr, tx, bm, wn};
    endfunction

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic check_cycle(logic [3:0] exp, string ctx);
        logic [3:0] got;
        logic [3:0] diff;
        string tag;
        got  = {tr_gate, tx_pulse, beam_en, rx_window};
        diff = got ^ exp;
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            if (diff[1])      tag = "R2";
            else if (diff[2]) tag = "R3";
            else if (diff[3]) tag = "R4";
            else              tag = "R5";
            $display("FAIL %s (%s) at %0t: got %b expected %b [tr tx beam win]",
                     tag, ctx, $time, got, exp);
        end
        n_vec++;
        if ((tx_pulse && !tr_gate) || (rx_window && tr_gate)) begin
            n_bad++;
            $display("FAIL R9 exclusion at %0t: got tr=%b tx=%b win=%b expected tx<=tr, win<=!tr",
                     $time, tr_gate, tx_pulse, rx_window);
        end
    endtask

    task automatic drive(int prt, int code, int ws, int wl, bit run);
        cfg_prt_us       = TW'(prt);
        cfg_pw_code      = 2'(code);
        cfg_win_start_us = TW'(ws);
        cfg_win_len_us   = TW'(wl);
        run_en           = run;
    endtask

    // Called at a clock edge while idle; returns at the edge that starts the period.
    task automatic start_run(int prt, int code, int ws, int wl);
        #1 drive(prt, code, ws, wl, 1'b1);
        @(posedge clk);
        #1 check_cycle(4'b0000, "R2 init cycle");
        @(posedge clk);
    endtask

    // Called at the edge that starts a period; checks every cycle of it.
    // Next settings are applied right after the start (R7: must not take effect).
    task automatic run_pulse(int prt, int code, int ws, int wl,
                             int nprt, int ncode, int nws, int nwl, bit nrun);
        int cycles;
        cycles = period_of(prt) * DIV;
        for (int k = 0; k < cycles; k++) begin
            #1 check_cycle(expect_at(k / DIV, prt, code, ws, wl),
                           (k == 0) ? "R6 period start" : "R7 settings held");
            if (k == 0) drive(nprt, ncode, nws, nwl, nrun);
            @(posedge clk);
        end
    endtask

    task automatic check_quiet(int n, string ctx);
        for (int k = 0; k < n; k++) begin
            #1 check_cycle(4'b0000, ctx);
            @(posedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL R6 watchdog: got run still active, expected completion");
            print_summary();
            $finish;
        end
    end

    initial begin
        int p, c, ws, wl, np, nc, nws, nwl;
        bit nrun;
        void'($urandom(32'd2024));

        repeat (4) @(posedge clk);
        #1 check_cycle(4'b0000, "R1 during reset");
        rst_n = 1'b1;
        @(posedge clk);
        check_quiet(40, "R1 idle with run_en low");

        // Directed: nominal window at 540 µs, 20 µs pulse.
        start_run(600, 0, 540, 40);
        // Next period: window runs past the end and must be cut (R5).
        run_pulse(600, 0, 540, 40, 600, 1, 500, 300, 1'b1);
        // Next: PRT below minimum (R6) and window start inside the gate span (R5).
        run_pulse(600, 1, 500, 300, 10, 2, 50, 20, 1'b1);
        // Next: zero-length window, widest pulse; run_en drops mid-period (R8).
        run_pulse(10, 2, 50, 20, 400, 3, 200, 0, 1'b0);
        check_quiet(400, "R8 idle after stop");

        start_run(400, 3, 200, 0);
        run_pulse(400, 3, 200, 0, 300, 0, 160, 60, 1'b1);
        p = 300; c = 0; ws = 160; wl = 60;

        // Random settings, with occasional stops and restarts.
        for (int i = 0; i < 30; i++) begin
            np   = $urandom_range(700, 100);
            nc   = $urandom_range(3, 0);
            nws  = $urandom_range(600, 100);
            nwl  = $urandom_range(300, 0);
            nrun = ($urandom_range(7, 0) != 0);
            run_pulse(p, c, ws, wl, np, nc, nws, nwl, nrun);
            if (!nrun) begin
                check_quiet(50, "R8 idle after stop");
                start_run(np, nc, nws, nwl);
            end
            p = np; c = nc; ws = nws; wl = nwl;
        end
        run_pulse(p, c, ws, wl, p, c, ws, wl, 1'b0);
        check_quiet(60, "R8 final idle");

        ended = 1'b1;
        print_summary();
        $finish;
    end

endmodule